// File: doc/BRIEF.md
# Conversion Completion Flag Register

This block keeps one completion flag per conversion slot of an analog-to-digital sequencer, eight slots by default. The sequencer pulses `set_valid` with a slot index when the conversion in that slot has finished and its result has been stored. The CPU side sees the flags as a read-only status word on `flags`. Bus-decode logic drives single-cycle strobes for a status read, a result read (with the slot index of the result register read), and a write to the control register that starts a new sequence.

Flags are cleared in one of two ways, chosen by `fast_clear_mode`. With the mode off, clearing takes a pair of reads. A status read arms every flag it returned as 1, and a later result read of an armed slot clears that flag. With the mode on, a result read alone clears the flag. A sequence-start write clears every flag. When a set and a clear reach the same flag in the same cycle, the winner depends on the source of the clear. The sequence-start clear beats the set, and the set beats a clear from a result read.

Top module: `conv_done_flags`

## Requirements
- R1: While reset is asserted, and after it is released, all flags and all armed states are 0. Reset is asynchronous and active-low, and its release is synchronised with a two-stage register.
- R2: A `set_valid` pulse with `set_index` = k makes bit k of `flags` read 1 after the next rising clock edge. Bit k stands for slot k of the register. No flag rises without a set pulse.
- R3: A `seq_start_write` pulse makes every flag read 0 after the next edge and discards all armed states.
- R4: With `fast_clear_mode` = 0, a result read of slot k that was not armed leaves flag k at 1.
- R5: With `fast_clear_mode` = 0, a status read arms only the flags it returned as 1. A later result read of an armed slot k clears flag k.
- R6: With `fast_clear_mode` = 1, a result read of slot k clears flag k with no status read needed.
- R7: A set and a sequence-start write in the same cycle leave the flag at 0.
- R8: A set and a result-read clear of the same slot in the same cycle leave the flag at 1, in either mode.
- R9: Any result read of slot k in non-fast mode uses up the armed state of k. While `fast_clear_mode` = 1, all armed states are dropped. After either event, a later result read clears nothing until a new status read arms the slot.
- R10: A result read of slot j leaves the flags of all other slots unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fast_clear_mode | input | 1 | 1: a result read alone clears the flag |
| set_valid | input | 1 | Conversion-complete pulse from the sequencer |
| set_index | input | IDX_W | Slot that completed |
| status_read | input | 1 | Strobe: the flag register was read |
| result_read | input | 1 | Strobe: a result register was read |
| result_index | input | IDX_W | Slot of the result register that was read |
| seq_start_write | input | 1 | Strobe: write that starts a new sequence |
| flags | output | NUM_SLOTS | Completion flags, bit k for slot k |

## Verification
The bench builds the block with the default NUM_SLOTS = 8, which gives a 3-bit index. At that size every slot can be set and read in turn, and every collision case fits in a short vector walk: a set against a sequence start, a set against a fast-mode result read, and a set against an armed non-fast result read. The walk also covers stale arms left across a mode change or a sequence start, and a status read that lands in the same cycle as a result read. Directed tests then apply reset in the middle of a run while slots are armed.

// File: rtl/cdf_pkg.sv
package cdf_pkg;
  // Number of bits needed to index n slots (at least 1).
  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/cdf_reset_sync.sv
module cdf_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_d;
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/cdf_index_decode.sv
module cdf_index_decode #(
  parameter int NUM_SLOTS = 8,
  parameter int IDX_W     = cdf_pkg::idx_bits(NUM_SLOTS)
) (
  input  logic                 en,
  input  logic [IDX_W-1:0]     idx,
  output logic [NUM_SLOTS-1:0] onehot
);
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_dec
    assign onehot[g] = en && (idx == IDX_W'(g));
  end
endmodule

// File: rtl/cdf_arm_tracker.sv
module cdf_arm_tracker #(
  parameter int NUM_SLOTS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fast_mode,
  input  logic                 status_rd,
  input  logic                 seq_clr,
  input  logic [NUM_SLOTS-1:0] cur_flags,
  input  logic [NUM_SLOTS-1:0] consume_vec,
  input  logic [NUM_SLOTS-1:0] clear_vec,
  output logic [NUM_SLOTS-1:0] armed
);
  logic [NUM_SLOTS-1:0] armed_q;
  logic [NUM_SLOTS-1:0] armed_d;
  logic                 armed_en;

  always_comb begin
    if (seq_clr || fast_mode) begin
      armed_d = '0;
    end else begin
      armed_d = armed_q & ~consume_vec;
      if (status_rd) armed_d = armed_d | (cur_flags & ~clear_vec);
    end
    armed_en = (armed_d != armed_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        armed_q <= '0;
    else if (armed_en) armed_q <= armed_d;
  end

  assign armed = armed_q;
endmodule

// File: rtl/cdf_flag_bank.sv
module cdf_flag_bank #(
  parameter int NUM_SLOTS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 seq_clr,
  input  logic [NUM_SLOTS-1:0] set_vec,
  input  logic [NUM_SLOTS-1:0] rd_clr_vec,
  output logic [NUM_SLOTS-1:0] flags
);
  logic [NUM_SLOTS-1:0] flag_q;
  logic [NUM_SLOTS-1:0] flag_d;
  logic [NUM_SLOTS-1:0] flag_en;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_bit
    always_comb begin
      flag_en[g] = seq_clr || set_vec[g] || rd_clr_vec[g];
      if (seq_clr)          flag_d[g] = 1'b0;  // start clear beats set
      else if (set_vec[g])  flag_d[g] = 1'b1;  // set beats read clear
      else                  flag_d[g] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_q[g] <= 1'b0;
      else if (flag_en[g]) flag_q[g] <= flag_d[g];
    end
  end

  assign flags = flag_q;
endmodule

// File: rtl/conv_done_flags.sv
module conv_done_flags #(
  parameter  int NUM_SLOTS = 8,
  localparam int IDX_W     = cdf_pkg::idx_bits(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fast_clear_mode,
  input  logic                 set_valid,
  input  logic [IDX_W-1:0]     set_index,
  input  logic                 status_read,
  input  logic                 result_read,
  input  logic [IDX_W-1:0]     result_index,
  input  logic                 seq_start_write,
  output logic [NUM_SLOTS-1:0] flags
);
  logic                 rst_sync_n;
  logic [NUM_SLOTS-1:0] set_vec;
  logic [NUM_SLOTS-1:0] rd_vec;
  logic [NUM_SLOTS-1:0] armed;
  logic [NUM_SLOTS-1:0] rd_clr_vec;
  logic [NUM_SLOTS-1:0] consume_vec;
  logic [NUM_SLOTS-1:0] clear_vec;

  cdf_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cdf_index_decode #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_set_dec (
    .en     (set_valid),
    .idx    (set_index),
    .onehot (set_vec)
  );

  cdf_index_decode #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_rd_dec (
    .en     (result_read),
    .idx    (result_index),
    .onehot (rd_vec)
  );

  always_comb begin
    rd_clr_vec  = fast_clear_mode ? rd_vec : (rd_vec & armed);
    consume_vec = fast_clear_mode ? '0 : rd_vec;
    clear_vec   = rd_clr_vec & ~set_vec;
  end

  cdf_flag_bank #(.NUM_SLOTS(NUM_SLOTS)) u_bank (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .seq_clr    (seq_start_write),
    .set_vec    (set_vec),
    .rd_clr_vec (rd_clr_vec),
    .flags      (flags)
  );

  cdf_arm_tracker #(.NUM_SLOTS(NUM_SLOTS)) u_arm (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .fast_mode   (fast_clear_mode),
    .status_rd   (status_read),
    .seq_clr     (seq_start_write),
    .cur_flags   (flags),
    .consume_vec (consume_vec),
    .clear_vec   (clear_vec),
    .armed       (armed)
  );
endmodule

// File: rtl/conv_done_flags_chk.sv
module conv_done_flags_chk #(
  parameter int NUM_SLOTS = 8,
  parameter int IDX_W     = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 fast_clear_mode,
  input logic                 set_valid,
  input logic [IDX_W-1:0]     set_index,
  input logic                 result_read,
  input logic [IDX_W-1:0]     result_index,
  input logic                 seq_start_write,
  input logic [NUM_SLOTS-1:0] armed,
  input logic [NUM_SLOTS-1:0] flags
);
  // R3 / R7: sequence start empties the register whatever else happens
  a_r3_seq_clear: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start_write |=> (flags == '0));

  // R2 / R8: a set without sequence start always lands
  a_r2_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (set_valid && !seq_start_write) |=> flags[$past(set_index)]);

  // R2: no flag rises without a set pulse
  a_r2_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    !set_valid |=> ((flags & ~$past(flags)) == '0));

  // R6: fast mode result read clears the slot
  a_r6_fast_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_clear_mode && result_read && !seq_start_write &&
     !(set_valid && set_index == result_index))
    |=> !flags[$past(result_index)]);

  // R4: an unarmed result read in non-fast mode keeps the flag
  a_r4_unarmed_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (!fast_clear_mode && result_read && !seq_start_write &&
     flags[result_index] && !armed[result_index])
    |=> flags[$past(result_index)]);

  // R9: fast mode leaves nothing armed
  a_r9_fast_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    fast_clear_mode |=> (armed == '0));
endmodule

bind conv_done_flags conv_done_flags_chk #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_sync_n),
  .fast_clear_mode (fast_clear_mode),
  .set_valid       (set_valid),
  .set_index       (set_index),
  .result_read     (result_read),
  .result_index    (result_index),
  .seq_start_write (seq_start_write),
  .armed           (armed),
  .flags           (flags)
);

// File: tb/conv_done_flags_test.sv
`timescale 1ns/100ps
module conv_done_flags_test;
  typedef struct packed {
    logic       fast;
    logic       setv;
    logic [2:0] sidx;
    logic       sread;
    logic       rread;
    logic [2:0] ridx;
    logic       seq;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 25;
  // fields: fast, setv, sidx, sread, rread, ridx, seq, expected flags, requirement
  localparam vec_t TABLE [NV] = '{
    '{1'b0, 1'b1, 3'd0, 1'b0, 1'b0, 3'd0, 1'b0, 8'h01, 4'd2},  // R2
    '{1'b0, 1'b1, 3'd3, 1'b0, 1'b0, 3'd0, 1'b0, 8'h09, 4'd2},  // R2
    '{1'b0, 1'b1, 3'd7, 1'b0, 1'b0, 3'd0, 1'b0, 8'h89, 4'd2},  // R2
    '{1'b0, 1'b0, 3'd0, 1'b0, 1'b1, 3'd3, 1'b0, 8'h89, 4'd4},  // R4 no status read yet
    '{1'b0, 1'b0, 3'd0, 1'b1, 1'b0, 3'd0, 1'b0, 8'h89, 4'd5},  // R5 arm 0,3,7
    '{1'b0, 1'b1, 3'd1, 1'b0, 1'b0, 3'd0, 1'b0, 8'h8B, 4'd2},  // R2 slot 1 not armed
    '{1'b0, 1'b0, 3'd0, 1'b0, 1'b1, 3'd1, 1'b0, 8'h8B, 4'd5},  // R5 read before arm
    '{1'b0, 1'b0, 3'd0, 1'b0, 1'b1, 3'd3, 1'b0, 8'h83, 4'd5},  // R5 armed clear
    '{1'b0, 1'b1, 3'd3, 1'b0, 1'b1, 3'd0, 1'b0, 8'h8A, 4'd10}, // R10 other slot untouched
    '{1'b0, 1'b0, 3'd0, 1'b0, 1'b1, 3'd3, 1'b0, 8'h8A, 4'd9},  // R9 arm used up
    '{1'b0, 1'b0, 3'd0, 1'b1, 1'b0, 3'd0, 1'b0, 8'h8A, 4'd5},  // R5 arm 1,3,7
    '{1'b0, 1'b1, 3'd7, 1'b0, 1'b1, 3'd7, 1'b0, 8'h8A, 4'd8},  // R8 set beats armed read
    '{1'b0, 1'b0, 3'd0, 1'b0, 1'b1, 3'd7, 1'b0, 8'h8A, 4'd9},  // R9 arm consumed in collision
    '{1'b1, 1'b0, 3'd0, 1'b0, 1'b1, 3'd1, 1'b0, 8'h88, 4'd6},  // R6 fast clear
    '{1'b1, 1'b1, 3'd5, 1'b0, 1'b1, 3'd5, 1'b0, 8'hA8, 4'd8},  // R8 set beats fast read
    '{1'b1, 1'b0, 3'd0, 1'b0, 1'b1, 3'd5, 1'b0, 8'h88, 4'd6},  // R6
    '{1'b0, 1'b0, 3'd0, 1'b0, 1'b1, 3'd3, 1'b0, 8'h88, 4'd9},  // R9 fast mode dropped arm
    '{1'b0, 1'b1, 3'd2, 1'b0, 1'b0, 3'd0, 1'b1, 8'h00, 4'd7},  // R7 start beats set
    '{1'b0, 1'b1, 3'd4, 1'b0, 1'b0, 3'd0, 1'b0, 8'h10, 4'd2},  // R2
    '{1'b0, 1'b0, 3'd0, 1'b1, 1'b0, 3'd0, 1'b0, 8'h10, 4'd5},  // R5 arm 4
    '{1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 3'd0, 1'b1, 8'h00, 4'd3},  // R3 clear all
    '{1'b0, 1'b1, 3'd4, 1'b0, 1'b0, 3'd0, 1'b0, 8'h10, 4'd2},  // R2
    '{1'b0, 1'b0, 3'd0, 1'b0, 1'b1, 3'd4, 1'b0, 8'h10, 4'd3},  // R3 start dropped arm
    '{1'b0, 1'b0, 3'd0, 1'b1, 1'b1, 3'd4, 1'b0, 8'h10, 4'd5},  // R5 read uses old arm
    '{1'b0, 1'b0, 3'd0, 1'b0, 1'b1, 3'd4, 1'b0, 8'h00, 4'd5}   // R5 now armed
  };

  logic       clk;
  logic       rst_n;
  logic       fast_clear_mode;
  logic       set_valid;
  logic [2:0] set_index;
  logic       status_read;
  logic       result_read;
  logic [2:0] result_index;
  logic       seq_start_write;
  logic [7:0] flags;

  int n_checks;
  int n_fail;
  bit done;

  conv_done_flags #(.NUM_SLOTS(8)) uut (
    .clk             (clk),
    .rst_n           (rst_n),
    .fast_clear_mode (fast_clear_mode),
    .set_valid       (set_valid),
    .set_index       (set_index),
    .status_read     (status_read),
    .result_read     (result_read),
    .result_index    (result_index),
    .seq_start_write (seq_start_write),
    .flags           (flags)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [7:0] exp);
    n_checks++;
    if (flags !== exp) begin
      n_fail++;
      $display("FAIL %s: flags=%h expected=%h", req, flags, exp);
    end
  endtask

  task automatic idle();
    set_valid = 1'b0; set_index = '0; status_read = 1'b0;
    result_read = 1'b0; result_index = '0; seq_start_write = 1'b0;
  endtask

  // drive at falling edge, sample just after the next rising edge
  task automatic step(input vec_t v);
    @(negedge clk);
    fast_clear_mode = v.fast; set_valid = v.setv; set_index = v.sidx;
    status_read = v.sread; result_read = v.rread; result_index = v.ridx;
    seq_start_write = v.seq;
    @(posedge clk); #1;
    idle();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async", 8'h00);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    n_checks = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; fast_clear_mode = 1'b0; idle();
    repeat (3) @(negedge clk);
    check("R1 in reset", 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after release", 8'h00);

    for (int i = 0; i < NV; i++) begin
      step(TABLE[i]);
      n_checks++;
      if (flags !== TABLE[i].exp) begin
        n_fail++;
        $display("FAIL R%0d vector %0d: flags=%h expected=%h",
                 TABLE[i].req, i, flags, TABLE[i].exp);
      end
    end

    // R2: every slot maps to its own bit
    for (int k = 0; k < 8; k++) begin
      step('{1'b0, 1'b1, 3'(k), 1'b0, 1'b0, 3'd0, 1'b0, 8'h00, 4'd2});
      check("R2 walk", 8'((1 << (k + 1)) - 1));
    end

    // R1: reset mid-run clears flags and arms
    step('{1'b0, 1'b0, 3'd0, 1'b1, 1'b0, 3'd0, 1'b0, 8'h00, 4'd1});
    do_reset();
    check("R1 flags after mid-run reset", 8'h00);
    step('{1'b0, 1'b1, 3'd6, 1'b0, 1'b0, 3'd0, 1'b0, 8'h00, 4'd1});
    check("R1 set after reset", 8'h40);
    step('{1'b0, 1'b0, 3'd0, 1'b0, 1'b1, 3'd6, 1'b0, 8'h00, 4'd1});
    check("R1 arm cleared by reset", 8'h40);

    // R10 fast mode: neighbour read leaves slot 6
    step('{1'b1, 1'b0, 3'd0, 1'b0, 1'b1, 3'd5, 1'b0, 8'h00, 4'd10});
    check("R10 fast neighbour", 8'h40);
    step('{1'b1, 1'b0, 3'd0, 1'b0, 1'b1, 3'd6, 1'b0, 8'h00, 4'd6});
    check("R6 fast single read", 8'h00);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: run did not finish");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule